// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept or dropped. A receive path hands it the frame identifier, the extended-format and remote-request flags, the data length code and the first two data bytes, together with four code lanes, four mask lanes and two mode controls. A one-cycle `start` strobe captures all of these. Two clock edges later `done` pulses for one cycle and `accept` holds the verdict until the next decision replaces it.

When the filter is switched off (`enh_en` low), every frame is accepted. In single-filter mode the four lanes form one long pattern. In dual-filter mode they split into two shorter patterns, and a match on either one accepts the frame. Standard-format frames can also be screened on their leading data bytes.

The control is a three-state machine. ST_IDLE waits for a strobe. ST_EVAL holds the captured frame while the verdict is formed. ST_DONE presents the verdict. The transitions are: ST_IDLE to ST_EVAL on `start`; ST_EVAL to ST_DONE unconditionally; ST_DONE to ST_EVAL on `start`; and ST_DONE to ST_IDLE otherwise. A strobe that arrives during ST_EVAL is ignored.

Top module: `can_accept_filter`

## Requirements
- R1: Code lane k sits at bits [8k+7:8k] of `acc_code`, and mask lane k at the same bits of `acc_mask` guards it. A mask bit of 1 makes the corresponding frame bit a don't-care. A mask bit of 0 requires the frame bit to equal the code bit.
- R2: With `enh_en` low at the strobe, the verdict is accept, whatever the frame and lanes hold.
- R3: Single mode, extended frame. ID bits 28..21 are compared with lane 0, bits 20..13 with lane 1, bits 12..5 with lane 2, and bits 4..0 with lane 3 bits 7..3. The RTR flag is compared with lane 3 bit 2. No data byte is checked.
- R4: Single mode, standard frame. ID bits 10..3 are compared with lane 0, bits 2..0 with lane 1 bits 7..5, and the RTR flag with lane 1 bit 4.
- R5: Single mode, standard frame that is not a remote request. With DLC 0 no data check applies. With DLC 1 only data byte 0 is checked, against lane 2. With DLC 2 or more, data byte 0 is checked against lane 2 and data byte 1 against lane 3.
- R6: Dual mode, extended frame. The frame is accepted if ID bits 28..13 match lanes 0..1 or match lanes 2..3 (high byte first). The RTR flag is not compared.
- R7: Dual mode, standard frame. Filter A compares the ID and RTR with lanes 0..1 (same layout as R4) and data byte 0 with {lane 1 bits 3..0, lane 3 bits 3..0}, under the mask lanes built the same way. Filter B compares only the ID and RTR with lanes 2..3 (ID bits 10..3 in lane 2, bits 2..0 in lane 3 bits 7..5, RTR in lane 3 bit 4). A match on either filter accepts the frame. DLC is not consulted.
- R8: `done` is high for exactly one cycle, two rising edges after the edge that samples `start`. A `start` seen during ST_EVAL is ignored.
- R9: The mode, lane and frame inputs are sampled only at an accepted strobe. Changing them afterwards does not alter the pending verdict.
- R10: A synchronous active-high `rst` clears `done` and `accept` and returns the machine to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that captures a frame |
| enh_en | input | 1 | Filter enable; low accepts everything |
| single_mode | input | 1 | 1 = single filter, 0 = dual filter |
| acc_code | input | 32 | Four acceptance code lanes |
| acc_mask | input | 32 | Four acceptance mask lanes (1 = don't care) |
| frm_id | input | 29 | Frame identifier (standard uses bits 10..0) |
| frm_ext | input | 1 | Extended-format frame |
| frm_rtr | input | 1 | Remote request frame |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| done | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Verdict, held until the next one |

## Verification
The filter's widths are set by the CAN frame format, so the bench builds the block with its default values only. It sweeps every combination of enable and mode, frame format, RTR flag and a set of DLC values (0, 1, 2 and 8) over many pseudo-random lane patterns. Each frame is derived from the lanes with a few flipped bits, so both near-miss rejects and accepts occur in every layout. After each strobe, all inputs are inverted and a second strobe is fired during evaluation. This puts the capture rule and the ignored-strobe rule within reach of every frame.

// File: rtl/canflt_pkg.sv
package canflt_pkg;
    localparam int EXT_ID_W  = 29;
    localparam int STD_ID_W  = 11;
    localparam int LANE_W    = 8;
    localparam int LANES     = 4;
    localparam int CFG_W     = LANE_W * LANES;
    localparam int DLC_W     = 4;
    localparam int DUAL_ID_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } flt_state_e;

    typedef struct packed {
        logic [EXT_ID_W-1:0] id;
        logic                ext;
        logic                rtr;
        logic [DLC_W-1:0]    dlc;
        logic [LANE_W-1:0]   d0;
        logic [LANE_W-1:0]   d1;
    } flt_frame_t;

    typedef struct packed {
        logic             enh;
        logic             single;
        logic [CFG_W-1:0] code;
        logic [CFG_W-1:0] mask;
    } flt_cfg_t;
endpackage

// File: rtl/canflt_cmp.sv
module canflt_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] m,
    output logic         eq
);
    // a set mask bit removes that position from the comparison
    assign eq = ~|((a ^ b) & ~m);
endmodule

// File: rtl/canflt_single.sv
module canflt_single
    import canflt_pkg::*;
(
    input  logic [EXT_ID_W-1:0] id,
    input  logic                ext,
    input  logic                rtr,
    input  logic [DLC_W-1:0]    dlc,
    input  logic [LANE_W-1:0]   d0,
    input  logic [LANE_W-1:0]   d1,
    input  logic [CFG_W-1:0]    code,
    input  logic [CFG_W-1:0]    mask,
    output logic                hit
);
    logic [CFG_W-1:0] cw, mw;
    logic ext_eq, std_eq, d0_eq, d1_eq, data_ok;

    // lane 0 leads: build a big-endian pattern word
    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign cw[CFG_W-1-k*LANE_W -: LANE_W] = code[k*LANE_W +: LANE_W];
            assign mw[CFG_W-1-k*LANE_W -: LANE_W] = mask[k*LANE_W +: LANE_W];
        end
    endgenerate

    // lane 3 bits 1..0 carry no field: they are compared with themselves
    canflt_cmp #(.W(CFG_W)) u_ext (
        .a({id, rtr, cw[1:0]}), .b(cw), .m(mw), .eq(ext_eq));

    canflt_cmp #(.W(STD_ID_W+1)) u_std (
        .a({id[STD_ID_W-1:0], rtr}),
        .b(cw[CFG_W-1 -: STD_ID_W+1]),
        .m(mw[CFG_W-1 -: STD_ID_W+1]),
        .eq(std_eq));

    canflt_cmp #(.W(LANE_W)) u_d0 (
        .a(d0), .b(code[2*LANE_W +: LANE_W]), .m(mask[2*LANE_W +: LANE_W]), .eq(d0_eq));
    canflt_cmp #(.W(LANE_W)) u_d1 (
        .a(d1), .b(code[3*LANE_W +: LANE_W]), .m(mask[3*LANE_W +: LANE_W]), .eq(d1_eq));

    always_comb begin
        if (rtr || dlc == '0)
            data_ok = 1'b1;
        else if (dlc == DLC_W'(1))
            data_ok = d0_eq;
        else
            data_ok = d0_eq && d1_eq;
        hit = ext ? ext_eq : (std_eq && data_ok);
    end
endmodule

// File: rtl/canflt_dual.sv
module canflt_dual
    import canflt_pkg::*;
(
    input  logic [DUAL_ID_W-1:0] id_hi,
    input  logic [STD_ID_W-1:0]  id_lo,
    input  logic                 ext,
    input  logic                 rtr,
    input  logic [LANE_W-1:0]    d0,
    input  logic [CFG_W-1:0]     code,
    input  logic [CFG_W-1:0]     mask,
    output logic                 hit
);
    localparam int HALF = 2 * LANE_W;
    localparam int NIB  = LANE_W / 2;

    logic [1:0] ext_hit, std_hit;
    logic       dq_eq;

    // filter f uses lanes 2f and 2f+1, lower lane number as high byte
    genvar f;
    generate
        for (f = 0; f < 2; f++) begin : g_filt
            logic [HALF-1:0] pc, pm;
            assign pc = {code[2*f*LANE_W +: LANE_W], code[(2*f+1)*LANE_W +: LANE_W]};
            assign pm = {mask[2*f*LANE_W +: LANE_W], mask[(2*f+1)*LANE_W +: LANE_W]};
            canflt_cmp #(.W(HALF)) u_e (
                .a(id_hi), .b(pc), .m(pm), .eq(ext_hit[f]));
            canflt_cmp #(.W(STD_ID_W+1)) u_s (
                .a({id_lo, rtr}), .b(pc[HALF-1 -: STD_ID_W+1]),
                .m(pm[HALF-1 -: STD_ID_W+1]), .eq(std_hit[f]));
        end
    endgenerate

    canflt_cmp #(.W(LANE_W)) u_dq (
        .a(d0),
        .b({code[LANE_W +: NIB], code[3*LANE_W +: NIB]}),
        .m({mask[LANE_W +: NIB], mask[3*LANE_W +: NIB]}),
        .eq(dq_eq));

    always_comb begin
        if (ext)
            hit = |ext_hit;
        else
            hit = (std_hit[0] && dq_eq) || std_hit[1];
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import canflt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                enh_en,
    input  logic                single_mode,
    input  logic [CFG_W-1:0]    acc_code,
    input  logic [CFG_W-1:0]    acc_mask,
    input  logic [EXT_ID_W-1:0] frm_id,
    input  logic                frm_ext,
    input  logic                frm_rtr,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [LANE_W-1:0]   frm_data0,
    input  logic [LANE_W-1:0]   frm_data1,
    output logic                done,
    output logic                accept
);
    flt_state_e state_q, state_d;
    flt_frame_t frm_q;
    flt_cfg_t   cfg_q;
    logic       launch, single_hit, dual_hit, verdict;
    logic       done_q, accept_q;

    assign launch = start && (state_q != ST_EVAL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // capture at an accepted strobe only
    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '0;
            cfg_q <= '0;
        end else if (launch) begin
            frm_q <= '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc,
                       d0: frm_data0, d1: frm_data1};
            cfg_q <= '{enh: enh_en, single: single_mode, code: acc_code, mask: acc_mask};
        end
    end

    canflt_single u_single (
        .id(frm_q.id), .ext(frm_q.ext), .rtr(frm_q.rtr), .dlc(frm_q.dlc),
        .d0(frm_q.d0), .d1(frm_q.d1), .code(cfg_q.code), .mask(cfg_q.mask),
        .hit(single_hit));

    canflt_dual u_dual (
        .id_hi(frm_q.id[EXT_ID_W-1 -: DUAL_ID_W]), .id_lo(frm_q.id[STD_ID_W-1:0]),
        .ext(frm_q.ext), .rtr(frm_q.rtr), .d0(frm_q.d0),
        .code(cfg_q.code), .mask(cfg_q.mask), .hit(dual_hit));

    assign verdict = !cfg_q.enh || (cfg_q.single ? single_hit : dual_hit);

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_EVAL);
            if (state_q == ST_EVAL) accept_q <= verdict;
        end
    end

    assign done   = done_q;
    assign accept = accept_q;

    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(launch, 2));
    a_r8_no_early: assert property (@(posedge clk) disable iff (rst)
        launch |=> !done_q);
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r2_enh_off: assert property (@(posedge clk) disable iff (rst)
        (done_q && !cfg_q.enh) |-> accept_q);
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!done_q && !accept_q && state_q == ST_IDLE));
endmodule

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
    logic        clk = 1'b0;
    logic        rst, start, enh_en, single_mode;
    logic [31:0] acc_code, acc_mask;
    logic [28:0] frm_id;
    logic        frm_ext, frm_rtr;
    logic [3:0]  frm_dlc;
    logic [7:0]  frm_data0, frm_data1;
    logic        done, accept;

    int errors = 0;
    int checks = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    can_accept_filter u_can_accept_filter (
        .clk(clk), .rst(rst), .start(start), .enh_en(enh_en), .single_mode(single_mode),
        .acc_code(acc_code), .acc_mask(acc_mask), .frm_id(frm_id), .frm_ext(frm_ext),
        .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data0(frm_data0), .frm_data1(frm_data1),
        .done(done), .accept(accept));

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic rnd(output logic [31:0] v);
        rng = nxt(rng);
        v = rng;
    endtask

    function automatic bit bit_ok(input logic f, input logic [31:0] c, input logic [31:0] m, input int bp);
        return m[bp] || (f == c[bp]);
    endfunction

    // ID bit i, counting bits from the top of a field that starts in lane b0
    function automatic int pos(input int b0, input int top, input int i);
        return 8 * (b0 + (top - i) / 8) + 7 - ((top - i) % 8);
    endfunction

    function automatic bit std_ok(input int b0, input logic [31:0] c, input logic [31:0] m,
                                  input logic [28:0] id, input logic rtr);
        bit ok = 1;
        for (int i = 0; i <= 10; i++) if (!bit_ok(id[i], c, m, pos(b0, 10, i))) ok = 0;
        if (!bit_ok(rtr, c, m, 8 * (b0 + 1) + 4)) ok = 0;
        return ok;
    endfunction

    function automatic bit model(input bit en, input bit sgl, input logic [31:0] c, input logic [31:0] m,
                                 input logic [28:0] id, input logic ext, input logic rtr,
                                 input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1);
        bit ok, okb, dq0, dq1;
        if (!en) return 1;
        if (sgl) begin
            if (ext) begin
                ok = 1;
                for (int i = 0; i <= 28; i++) if (!bit_ok(id[i], c, m, pos(0, 28, i))) ok = 0;
                if (!bit_ok(rtr, c, m, 26)) ok = 0;
                return ok;
            end
            if (!std_ok(0, c, m, id, rtr)) return 0;
            if (rtr || dlc == 0) return 1;
            dq0 = 1; dq1 = 1;
            for (int j = 0; j < 8; j++) begin
                if (!bit_ok(d0[j], c, m, 16 + j)) dq0 = 0;
                if (!bit_ok(d1[j], c, m, 24 + j)) dq1 = 0;
            end
            return (dlc == 1) ? dq0 : (dq0 && dq1);
        end
        if (ext) begin
            ok = 1; okb = 1;
            for (int i = 13; i <= 28; i++) begin
                if (!bit_ok(id[i], c, m, pos(0, 28, i))) ok = 0;
                if (!bit_ok(id[i], c, m, pos(2, 28, i))) okb = 0;
            end
            return ok || okb;
        end
        dq0 = 1;
        for (int j = 0; j < 8; j++)
            if (!bit_ok(d0[j], c, m, (j >= 4) ? (8 + j - 4) : (24 + j))) dq0 = 0;
        return (std_ok(0, c, m, id, rtr) && dq0) || std_ok(2, c, m, id, rtr);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input string tag, input bit en, input bit sgl,
                             input logic [31:0] c, input logic [31:0] m, input logic [28:0] id,
                             input logic ext, input logic rtr, input logic [3:0] dlc,
                             input logic [7:0] d0, input logic [7:0] d1);
        bit exp = model(en, sgl, c, m, id, ext, rtr, dlc, d0, d1);
        @(negedge clk);
        enh_en = en; single_mode = sgl; acc_code = c; acc_mask = m;
        frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc; frm_data0 = d0; frm_data1 = d1;
        start = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R8 early done", 32'(done), 0);
        // R9: change everything after capture; R8: strobe during evaluation is ignored
        enh_en = ~en; single_mode = ~sgl; acc_code = ~c; acc_mask = ~m;
        frm_id = ~id; frm_ext = ~ext; frm_rtr = ~rtr; frm_dlc = ~dlc; frm_data0 = ~d0; frm_data1 = ~d1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R8 done at latency 2", 32'(done), 1);
        chk(accept == exp, tag, 32'(accept), 32'(exp));
        @(negedge clk);
        chk(done == 1'b0, "R8 single-cycle done", 32'(done), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] c, m, r1, r2, r3, w;
        logic [28:0] id;
        logic [7:0]  d0, d1;
        logic [3:0]  dlc;
        string       tag;
        rst = 1'b1; start = 1'b0; enh_en = 1'b0; single_mode = 1'b0;
        acc_code = '0; acc_mask = '0; frm_id = '0; frm_ext = 1'b0; frm_rtr = 1'b0;
        frm_dlc = '0; frm_data0 = '0; frm_data1 = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && accept == 1'b0, "R10 reset state", {30'd0, done, accept}, 0);
        rst = 1'b0;

        // R1: all-ones mask accepts anything; all-zero mask needs an exact match
        run_frame("R1 full mask", 1, 1, 32'hA5C3_1E77, 32'hFFFF_FFFF, 29'h0ABC_DEF1, 1, 1, 4'd5, 8'h12, 8'h34);
        w = {8'h3C, 8'h5A, 8'h96, 8'hF8};   // lanes 3..0 -> pattern bytes
        run_frame("R1 exact match", 1, 1, {w[7:0], w[15:8], w[23:16], w[31:24]}, 32'h0,
                  w[31:3], 1, w[2], 4'd0, 8'h00, 8'h00);
        run_frame("R1 one bit off", 1, 1, {w[7:0], w[15:8], w[23:16], w[31:24]}, 32'h0,
                  w[31:3] ^ 29'h100, 1, w[2], 4'd0, 8'h00, 8'h00);

        for (int mode = 0; mode < 3; mode++)
            for (int e = 0; e < 2; e++)
                for (int r = 0; r < 2; r++)
                    for (int di = 0; di < 4; di++)
                        for (int s = 0; s < 24; s++) begin
                            rnd(c); rnd(m); rnd(r1); rnd(r2); rnd(r3);
                            m = m & r1;   // sparse masks make matches selective
                            dlc = (di == 3) ? 4'd8 : 4'(di);
                            w = {c[7:0], c[15:8], c[23:16], c[31:24]};
                            rnd(r1);
                            if (e == 1) id = w[31:3] ^ (r1[28:0] & r2[28:0] & r3[28:0]);
                            else if (mode == 2 && r1[31]) id = {18'd0, w[15:5] ^ (r2[10:0] & r3[10:0] & r1[10:0])};
                            else id = {18'd0, w[31:21] ^ (r2[10:0] & r3[10:0] & r1[10:0])};
                            rnd(r1);
                            d0 = ((mode == 2) ? {c[11:8], c[27:24]} : c[23:16]) ^ (r1[7:0] & r2[15:8] & r3[15:8]);
                            d1 = c[31:24] ^ (r1[15:8] & r2[23:16] & r3[23:16]);
                            if (mode == 0)      tag = "R2 filter off";
                            else if (mode == 1) tag = e ? "R3 single ext"
                                                        : ((r == 0 && dlc != 0) ? "R5 single std data" : "R4 single std id");
                            else                tag = e ? "R6 dual ext" : "R7 dual std";
                            run_frame(tag, mode != 0, mode == 1, c, m, id, e[0], r[0], dlc, d0, d1);
                        end

        // R10: reset while a verdict is pending clears the outputs
        @(negedge clk);
        enh_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0 && accept == 1'b0, "R10 reset mid-evaluation", {30'd0, done, accept}, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 no done after reset", 32'(done), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule